// File: doc/BRIEF.md
# Five-Phase Sequential RISC Core

This block is a small non-pipelined processor. Every instruction is carried through five phases, one clock cycle each: fetch, decode with operand read, execute, memory access and write-back. The next fetch starts only after the write-back of the previous instruction, so each instruction takes exactly five cycles. The core holds the program counter, a 32-entry register file, an ALU and the phase sequencer.

The core is connected to an instruction memory and a data memory. Both are word-addressed arrays outside the core with a synchronous read. The core understands three operations: a register-register add, a move of a zero-extended immediate, and a store to a base register plus an offset. A phase code output and a one-cycle retire pulse let a testbench or a neighbouring block follow the instruction timing.

Top module: `mc_core`

## Requirements
- R1: While `rst_n` is low and in the first cycle after release, `phase_o` is 0, `imem_addr` is 0, `retire` and `dmem_we` are low, and every register holds zero.
- R2: `phase_o` steps 0 (fetch), 1 (decode), 2 (execute), 3 (memory), 4 (write-back) and back to 0, one cycle per step, and `retire` is high exactly in the write-back cycle.
- R3: `imem_rd` is high only in the fetch cycle, and the fetch of the n-th instruction after reset (counting from 0) presents address n on `imem_addr`.
- R4: Instruction bits [20:15] are the opcode and bits [14:10], [9:5], [4:0] are fields A, B, C; opcode 000111 writes the sum of registers B and C, modulo 2^16, to register A.
- R5: Opcode 000001 writes bits [9:0] of the instruction, zero-extended to 16 bits, to register A.
- R6: Opcode 111001 raises `dmem_we` for the single memory-phase cycle, with `dmem_addr` equal to register B plus the zero-extended 5-bit field C (modulo 2^16) and `dmem_wdata` equal to register A.
- R7: A register is written only at the end of write-back, so an instruction that names its destination as a source uses the value held before that instruction.
- R8: Register 0 always reads as zero; writes to it have no effect.
- R9: Any other opcode takes five cycles and changes neither a register nor data memory.
- R10: `dmem_we` is low in every cycle other than the memory phase of a store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| imem_rd | output | 1 | Instruction memory read strobe, fetch phase |
| imem_addr | output | PCW (8) | Instruction word address (program counter) |
| imem_rdata | input | 21 | Instruction word, valid the cycle after the read |
| dmem_we | output | 1 | Data memory write strobe |
| dmem_addr | output | DW (16) | Data memory word address |
| dmem_wdata | output | DW (16) | Data memory write data |
| phase_o | output | 3 | Current phase code, 0 to 4 |
| retire | output | 1 | High in the write-back cycle |

## Verification
The bench follows instructions whose destination is also a source. A core that wrote the register file before write-back would double an already doubled value there. Writes to register 0 are stored back afterwards and must read as zero; an undefined opcode with add-like fields must leave its target untouched; a chain of doublings tests the 16-bit wrap of the adder; and a store with the largest offset tests the zero extension of the offset. A core with a phase skipped or repeated, or with the program counter advanced at the wrong time, shows up at the phase, retire and fetch-address checks made in every cycle.

// File: rtl/mc_pkg.sv
`timescale 1ns/1ps
package mc_pkg;
  localparam int OPW = 6;
  localparam int FLDW = 5;
  localparam int INSTW = OPW + 3 * FLDW;

  typedef enum logic [2:0] {
    PH_IF  = 3'd0,
    PH_ID  = 3'd1,
    PH_EX  = 3'd2,
    PH_MEM = 3'd3,
    PH_WB  = 3'd4
  } phase_e;

  localparam logic [OPW-1:0] OP_ADD   = 6'b000111;
  localparam logic [OPW-1:0] OP_MOVI  = 6'b000001;
  localparam logic [OPW-1:0] OP_STORE = 6'b111001;

  typedef struct packed {
    logic [OPW-1:0]  op;
    logic [FLDW-1:0] fa;
    logic [FLDW-1:0] fb;
    logic [FLDW-1:0] fc;
  } instr_t;
endpackage

// File: rtl/mc_sequencer.sv
`timescale 1ns/1ps
module mc_sequencer
  import mc_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_e phase,
  output logic   retire
);
  phase_e phase_d;

  always_comb begin
    unique case (phase)
      PH_IF:   phase_d = PH_ID;
      PH_ID:   phase_d = PH_EX;
      PH_EX:   phase_d = PH_MEM;
      PH_MEM:  phase_d = PH_WB;
      default: phase_d = PH_IF;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= PH_IF;
    else        phase <= phase_d;
  end

  assign retire = (phase == PH_WB);

  p_phase_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (phase != PH_WB) |=> (3'(phase) == 3'($past(phase)) + 3'd1));
  p_retire_to_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> (phase == PH_IF));
endmodule

// File: rtl/mc_regfile.sv
`timescale 1ns/1ps
module mc_regfile #(
  parameter int DW   = 16,
  parameter int NREG = 32,
  localparam int AW  = $clog2(NREG)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] ra_addr,
  output logic [DW-1:0] ra_data,
  input  logic [AW-1:0] rb_addr,
  output logic [DW-1:0] rb_data,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data
);
  logic [DW-1:0] regs [NREG];

  assign regs[0] = '0;

  for (genvar g = 1; g < NREG; g++) begin : g_reg
    logic          hit;
    logic [DW-1:0] q;
    assign hit = wr_en && (wr_addr == AW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (hit) q <= wr_data;
    end
    assign regs[g] = q;
  end

  assign ra_data = regs[ra_addr];
  assign rb_data = regs[rb_addr];
endmodule

// File: rtl/mc_alu.sv
`timescale 1ns/1ps
module mc_alu
  import mc_pkg::*;
#(
  parameter int DW = 16
) (
  input  instr_t        instr,
  input  logic [DW-1:0] opa,
  input  logic [DW-1:0] opb,
  output logic [DW-1:0] result
);
  localparam int IMMW = 2 * FLDW;

  logic [DW-1:0] imm_ext;
  logic [DW-1:0] off_ext;

  assign imm_ext = {{(DW-IMMW){1'b0}}, instr.fb, instr.fc};
  assign off_ext = {{(DW-FLDW){1'b0}}, instr.fc};

  always_comb begin
    unique case (instr.op)
      OP_ADD:   result = opa + opb;
      OP_MOVI:  result = imm_ext;
      OP_STORE: result = opa + off_ext;
      default:  result = '0;
    endcase
  end
endmodule

// File: rtl/mc_core.sv
`timescale 1ns/1ps
module mc_core
  import mc_pkg::*;
#(
  parameter int DW   = 16,
  parameter int PCW  = 8,
  parameter int NREG = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic             imem_rd,
  output logic [PCW-1:0]   imem_addr,
  input  logic [INSTW-1:0] imem_rdata,
  output logic             dmem_we,
  output logic [DW-1:0]    dmem_addr,
  output logic [DW-1:0]    dmem_wdata,
  output logic [2:0]       phase_o,
  output logic             retire
);
  localparam int RAW = $clog2(NREG);

  phase_e        phase;
  logic [PCW-1:0] pc_q, pc_d;
  instr_t        instr_q, instr_d, dec;
  logic [DW-1:0] a_q, a_d, b_q, b_d, res_q, res_d;
  logic [DW-1:0] ra_data, rb_data, alu_y;
  logic [RAW-1:0] rb_sel;
  logic          rf_we;
  logic          pc_en, dec_en, ex_en;

  mc_sequencer u_seq (
    .clk    (clk),
    .rst_n  (rst_n),
    .phase  (phase),
    .retire (retire)
  );

  // operand read during decode, straight from the fetched word
  assign dec    = instr_t'(imem_rdata);
  assign rb_sel = (dec.op == OP_STORE) ? RAW'(dec.fa) : RAW'(dec.fc);

  mc_regfile #(.DW(DW), .NREG(NREG)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .ra_addr (RAW'(dec.fb)),
    .ra_data (ra_data),
    .rb_addr (rb_sel),
    .rb_data (rb_data),
    .wr_en   (rf_we),
    .wr_addr (RAW'(instr_q.fa)),
    .wr_data (res_q)
  );

  mc_alu #(.DW(DW)) u_alu (
    .instr  (instr_q),
    .opa    (a_q),
    .opb    (b_q),
    .result (alu_y)
  );

  assign pc_en  = (phase == PH_IF);
  assign dec_en = (phase == PH_ID);
  assign ex_en  = (phase == PH_EX);

  always_comb begin
    pc_d    = pc_q + PCW'(1);
    instr_d = dec;
    a_d     = ra_data;
    b_d     = rb_data;
    res_d   = alu_y;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc_q    <= '0;
      instr_q <= '0;
      a_q     <= '0;
      b_q     <= '0;
      res_q   <= '0;
    end else begin
      if (pc_en)  pc_q    <= pc_d;
      if (dec_en) instr_q <= instr_d;
      if (dec_en) a_q     <= a_d;
      if (dec_en) b_q     <= b_d;
      if (ex_en)  res_q   <= res_d;
    end
  end

  assign rf_we      = (phase == PH_WB) &&
                      ((instr_q.op == OP_ADD) || (instr_q.op == OP_MOVI));
  assign imem_rd    = (phase == PH_IF);
  assign imem_addr  = pc_q;
  assign dmem_we    = (phase == PH_MEM) && (instr_q.op == OP_STORE);
  assign dmem_addr  = res_q;
  assign dmem_wdata = b_q;
  assign phase_o    = 3'(phase);

  p_pc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    imem_rd |=> (imem_addr == $past(imem_addr) + PCW'(1)));
  p_pc_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !imem_rd |=> $stable(imem_addr));
  p_we_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> !dmem_we);
  p_we_before_retire_r10: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |=> retire);
  p_store_data_stable_r6: assert property (@(posedge clk) disable iff (!rst_n)
    dmem_we |-> $stable(dmem_wdata));
endmodule

// File: tb/mc_core_bench.sv
`timescale 1ns/1ps
module mc_core_bench;
  import mc_pkg::*;
  localparam int DW = 16;
  localparam int PCW = 8;
  localparam int NMAX = 1 << PCW;

  logic             clk;
  logic             rst_n;
  logic             imem_rd;
  logic [PCW-1:0]   imem_addr;
  logic [INSTW-1:0] imem_rdata;
  logic             dmem_we;
  logic [DW-1:0]    dmem_addr;
  logic [DW-1:0]    dmem_wdata;
  logic [2:0]       phase_o;
  logic             retire;

  mc_core u_mc_core (
    .clk        (clk),
    .rst_n      (rst_n),
    .imem_rd    (imem_rd),
    .imem_addr  (imem_addr),
    .imem_rdata (imem_rdata),
    .dmem_we    (dmem_we),
    .dmem_addr  (dmem_addr),
    .dmem_wdata (dmem_wdata),
    .phase_o    (phase_o),
    .retire     (retire)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [INSTW-1:0] imem [NMAX];
  logic             st_flag [NMAX];
  logic             ud_flag [NMAX];
  logic [DW-1:0]    rm [32];
  logic [DW-1:0]    ex_addr [NMAX];
  logic [DW-1:0]    ex_data [NMAX];
  string            ex_tag [NMAX];
  int n_prog, n_ex, n_seen, n_tests, n_fail;
  bit done;

  always @(posedge clk) if (imem_rd) imem_rdata <= imem[imem_addr];

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit legal(input logic [5:0] op);
    return (op == OP_ADD) || (op == OP_MOVI) || (op == OP_STORE);
  endfunction

  // write one instruction and advance the reference model
  task automatic emit(input logic [5:0] op, input logic [4:0] a,
                      input logic [4:0] b, input logic [4:0] c, input string tag);
    imem[n_prog]    = {op, a, b, c};
    st_flag[n_prog] = (op == OP_STORE);
    ud_flag[n_prog] = !legal(op);
    if (op == OP_ADD && a != 0)  rm[a] = rm[b] + rm[c];
    if (op == OP_MOVI && a != 0) rm[a] = {6'd0, b, c};
    if (op == OP_STORE) begin
      ex_addr[n_ex] = rm[b] + {11'd0, c};
      ex_data[n_ex] = rm[a];
      ex_tag[n_ex]  = tag;
      n_ex++;
    end
    n_prog++;
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
  endtask

  initial begin
    logic [5:0] rop;
    int unsigned seed;
    seed = $urandom(32'h5EED_0071);
    n_prog = 0; n_ex = 0; n_seen = 0; n_tests = 0; n_fail = 0; done = 0;
    for (int i = 0; i < 32; i++) rm[i] = '0;
    for (int i = 0; i < NMAX; i++) begin
      imem[i] = '0; st_flag[i] = 0; ud_flag[i] = 1;
    end
    // directed corner cases
    emit(OP_STORE, 5'd9, 5'd0, 5'd4, "R1");          // reset value of r9
    emit(OP_MOVI, 5'd2, 5'h01, 5'h0A, "R5");          // r2 = 2A
    emit(OP_MOVI, 5'd3, 5'h00, 5'h12, "R5");          // r3 = 12
    emit(OP_ADD, 5'd1, 5'd2, 5'd3, "R4");             // r1 = 3C
    emit(OP_STORE, 5'd1, 5'd4, 5'd0, "R4");
    emit(OP_MOVI, 5'd0, 5'h1F, 5'h1F, "R8");          // write to r0
    emit(OP_STORE, 5'd0, 5'd0, 5'd5, "R8");
    emit(OP_ADD, 5'd1, 5'd1, 5'd1, "R7");             // dest is source
    emit(OP_STORE, 5'd1, 5'd0, 5'd1, "R7");
    emit(6'h3F, 5'd1, 5'd2, 5'd3, "R9");              // undefined op
    emit(OP_STORE, 5'd1, 5'd0, 5'd2, "R9");
    emit(OP_MOVI, 5'd5, 5'h1F, 5'h1F, "R5");          // r5 = 3FF
    emit(OP_STORE, 5'd5, 5'd0, 5'd6, "R5");
    emit(OP_MOVI, 5'd6, 5'h1F, 5'h1F, "R5");
    for (int i = 0; i < 7; i++) emit(OP_ADD, 5'd6, 5'd6, 5'd6, "R4");
    emit(OP_STORE, 5'd6, 5'd0, 5'd3, "R4");           // wrapped sum
    emit(OP_STORE, 5'd5, 5'd6, 5'd31, "R6");          // max offset
    // constrained random section
    for (int i = 0; i < 60; i++) begin
      case ($urandom % 4)
        0: emit(OP_ADD, 5'($urandom), 5'($urandom), 5'($urandom), "R4");
        1: emit(OP_MOVI, 5'($urandom), 5'($urandom), 5'($urandom), "R5");
        2: emit(OP_STORE, 5'($urandom), 5'($urandom), 5'($urandom), "R6");
        default: begin
          rop = 6'($urandom);
          while (legal(rop)) rop = 6'($urandom);
          emit(rop, 5'($urandom), 5'($urandom), 5'($urandom), "R9");
        end
      endcase
    end
    // dump every register
    for (int i = 0; i < 32; i++) emit(OP_STORE, 5'(i), 5'd0, 5'(i), "R4");

    // reset checks
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(phase_o == 3'd0, "R1", "phase in reset", phase_o, 0);
    chk(imem_addr == '0, "R1", "pc in reset", imem_addr, 0);
    chk(!retire, "R1", "retire in reset", retire, 0);
    chk(!dmem_we, "R1", "dmem_we in reset", dmem_we, 0);
    rst_n = 1'b1;

    for (int k = 0; k < 5 * n_prog; k++) begin
      int idx, ph;
      idx = k / 5;
      ph  = k % 5;
      chk(phase_o == 3'(ph), "R2", "phase", phase_o, ph);
      chk(retire == (ph == 4), "R2", "retire", retire, ph == 4);
      chk(imem_rd == (ph == 0), "R3", "imem_rd", imem_rd, ph == 0);
      if (ph == 0) chk(imem_addr == PCW'(idx), "R3", "fetch address", imem_addr, idx);
      if (ph == 3 && st_flag[idx]) begin
        chk(dmem_we, "R6", "store strobe", dmem_we, 1);
        if (dmem_we && n_seen < n_ex) begin
          chk(dmem_addr == ex_addr[n_seen], ex_tag[n_seen], "store address",
              dmem_addr, ex_addr[n_seen]);
          chk(dmem_wdata == ex_data[n_seen], ex_tag[n_seen], "store data",
              dmem_wdata, ex_data[n_seen]);
          n_seen++;
        end
      end else begin
        chk(!dmem_we, ud_flag[idx] ? "R9" : "R10", "stray write", dmem_we, 0);
      end
      @(negedge clk);
    end
    chk(n_seen == n_ex, "R6", "store count", n_seen, n_ex);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end
endmodule